// File: doc/BRIEF.md
# Critical-Word-First Read Burst Serializer

This block sits on the read return path of a memory whose array delivers four beats of data in one wide word. It takes each wide word whole into a capture register and sends it out as four narrow beats on consecutive clock cycles. The four beats come out in a wrapping order. In critical-word-first mode, the slot named by the two low address bits of the matching read request leaves first and the rest follow in rising slot order modulo four. In fixed-start mode the burst always opens at slot 0, and the requested low bits play no part.

Read requests reach the block before their data. Each request records its start slot in a small in-order queue. The queue head is paired with the next wide word the serializer accepts. If a wide word arrives in the same cycle as a request and the queue is empty, that request applies to the word directly. A wide word presented while the serializer is on the last beat of a burst starts its own burst on the very next cycle, so successive bursts stream without a gap.

Top module: `cwf_burst_serializer`

## Requirements
- R1: After reset `beat_valid` is 0 and `beat_data` is 0.
- R2: When `req_cwf` is 1, the first beat of the burst is slot `req_addr`, where slot s is `wide_data[s*BEAT_W +: BEAT_W]`.
- R3: Beat k of a burst (k = 0..3) is slot (start + k) mod 4.
- R4: When `req_cwf` is 0, the burst starts at slot 0 whatever `req_addr` holds.
- R5: An accepted wide word yields `beat_valid` high for exactly four consecutive cycles. The first beat is visible in the cycle after `wide_valid` is sampled.
- R6: A wide word presented during the last-beat cycle of a burst is accepted, and its first beat follows in the next cycle with no idle cycle between the two bursts.
- R7: `wide_valid` is ignored while a burst has more than its last beat left to send. The current burst is unchanged, no extra burst is produced, and no queued request is consumed.
- R8: With no burst in progress, `beat_valid` is 0 and `beat_data` keeps the last beat sent.
- R9: Requests are paired with wide words in arrival order, and up to QDEPTH (default 4) requests can wait. A request arriving when the queue is full is dropped. A request that arrives with an empty queue in the same cycle as an accepted wide word applies to that word.
- R10: A wide word accepted while no request is pending is sent starting at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | 2 | Low address bits of the request |
| req_cwf | input | 1 | 1 = critical word first, 0 = fixed start at slot 0 |
| wide_valid | input | 1 | Wide word from the array is present |
| wide_data | input | 4*BEAT_W | Four slots of array data, slot s at bits s*BEAT_W |
| beat_data | output | BEAT_W | Narrow output beat |
| beat_valid | output | 1 | Output beat is valid |

## Verification
Two kinds of event can fall in the same cycle, and each has a different correct outcome. A new wide word can arrive while a burst is still playing: in the final-beat cycle it must chain on with no gap, but on an earlier beat it must be dropped without touching the queue. A request push can also coincide with a wide-word acceptance while the queue is empty, and then the incoming start slot must be used at once. The bench provokes each collision on chosen beats and judges it by the beat values and valid pattern that follow, and by the start slot the next queued word receives.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  localparam int SLOT_W    = 2;
  localparam int NUM_SLOTS = 1 << SLOT_W;

  typedef logic [SLOT_W-1:0] slot_t;

  // Slot that leaves first for a request.
  function automatic slot_t start_slot(input logic cwf, input slot_t addr);
    return cwf ? addr : slot_t'(0);
  endfunction

  // Linear successor, wrapping modulo NUM_SLOTS.
  function automatic slot_t next_slot(input slot_t s);
    return slot_t'(s + slot_t'(1));
  endfunction
endpackage

// File: rtl/cwf_req_queue.sv
module cwf_req_queue
  import cwf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  slot_t                        push_slot,
  input  logic                         pop,
  output slot_t                        head_slot,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  slot_t            mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic             empty, full, store, consume;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(p + 1'b1);
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  // An empty queue hands an incoming request straight to a pop.
  assign consume = pop && !empty;
  assign store   = push && !(empty && pop) && (!full || consume);

  always_comb begin
    if (!empty)    head_slot = mem[rd_ptr];
    else if (push) head_slot = push_slot;
    else           head_slot = slot_t'(0);
  end

  always_ff @(posedge clk) begin
    if (store) mem[wr_ptr] <= push_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (store)   wr_ptr <= ptr_inc(wr_ptr);
      if (consume) rd_ptr <= ptr_inc(rd_ptr);
      case ({store, consume})
        2'b10:   cnt_q <= CNT_W'(cnt_q + 1'b1);
        2'b01:   cnt_q <= CNT_W'(cnt_q - 1'b1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/cwf_capture_seq.sv
module cwf_capture_seq
  import cwf_pkg::*;
#(
  parameter int BEAT_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [NUM_SLOTS*BEAT_W-1:0]   load_word,
  input  slot_t                         load_slot,
  output logic [BEAT_W-1:0]             beat_data,
  output logic                          beat_valid,
  output logic                          last_beat,
  output logic                          free,
  output slot_t                         cur_slot
);
  localparam int WORD_W = NUM_SLOTS * BEAT_W;

  logic [WORD_W-1:0] word_q;
  slot_t             slot_q;
  logic [SLOT_W-1:0] rem_q;
  slot_t             adv_slot;

  assign adv_slot  = next_slot(slot_q);
  assign last_beat = beat_valid && (rem_q == '0);
  assign free      = !beat_valid || last_beat;
  assign cur_slot  = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q     <= '0;
      slot_q     <= '0;
      rem_q      <= '0;
      beat_data  <= '0;
      beat_valid <= 1'b0;
    end else if (load) begin
      word_q     <= load_word;
      slot_q     <= load_slot;
      rem_q      <= SLOT_W'(NUM_SLOTS - 1);
      beat_data  <= load_word[load_slot*BEAT_W +: BEAT_W];
      beat_valid <= 1'b1;
    end else if (beat_valid && rem_q != '0) begin
      slot_q    <= adv_slot;
      rem_q     <= SLOT_W'(rem_q - 1'b1);
      beat_data <= word_q[adv_slot*BEAT_W +: BEAT_W];
    end else begin
      beat_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cwf_burst_serializer.sv
module cwf_burst_serializer
  import cwf_pkg::*;
#(
  parameter int BEAT_W = 8,
  parameter int QDEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [1:0]                  req_addr,
  input  logic                        req_cwf,
  input  logic                        wide_valid,
  input  logic [4*BEAT_W-1:0]         wide_data,
  output logic [BEAT_W-1:0]           beat_data,
  output logic                        beat_valid
);
  localparam int CNT_W = $clog2(QDEPTH + 1);

  // Named internal events for the checker.
  logic             accept_evt;
  logic             last_beat_evt;
  logic             seq_free;
  slot_t            head_slot;
  slot_t            cur_slot;
  slot_t            push_slot;
  logic [CNT_W-1:0] q_count;

  assign push_slot  = start_slot(req_cwf, req_addr);
  assign accept_evt = wide_valid && seq_free;

  cwf_req_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (req_valid),
    .push_slot (push_slot),
    .pop       (accept_evt),
    .head_slot (head_slot),
    .count     (q_count)
  );

  cwf_capture_seq #(.BEAT_W(BEAT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept_evt),
    .load_word  (wide_data),
    .load_slot  (head_slot),
    .beat_data  (beat_data),
    .beat_valid (beat_valid),
    .last_beat  (last_beat_evt),
    .free       (seq_free),
    .cur_slot   (cur_slot)
  );
endmodule

// File: rtl/cwf_burst_serializer_chk.sv
module cwf_burst_serializer_chk #(
  parameter int BEAT_W = 8,
  parameter int QDEPTH = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              beat_valid,
  input logic [BEAT_W-1:0] beat_data,
  input logic              accept_evt,
  input logic              last_beat_evt,
  input logic              wide_valid,
  input logic [1:0]        cur_slot,
  input logic [CNT_W-1:0]  q_count
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !beat_valid); // R1

  AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !last_beat_evt && !accept_evt) |=>
      (cur_slot == 2'($past(cur_slot) + 2'd1))); // R3

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> beat_valid); // R5

  AST_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !last_beat_evt) |=> beat_valid); // R5

  AST_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat_evt && wide_valid) |-> accept_evt); // R6

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !last_beat_evt) |-> !accept_evt); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_evt && (!beat_valid || last_beat_evt)) |=>
      (!beat_valid && $stable(beat_data))); // R8

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(QDEPTH)); // R9
endmodule

bind cwf_burst_serializer cwf_burst_serializer_chk #(
  .BEAT_W (BEAT_W),
  .QDEPTH (QDEPTH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .beat_valid    (beat_valid),
  .beat_data     (beat_data),
  .accept_evt    (accept_evt),
  .last_beat_evt (last_beat_evt),
  .wide_valid    (wide_valid),
  .cur_slot      (cur_slot),
  .q_count       (q_count)
);

// File: tb/cwf_burst_serializer_bench.sv
`timescale 1ns/1ps
module cwf_burst_serializer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_addr = '0;
  logic        req_cwf = 1'b0;
  logic        wide_valid = 1'b0;
  logic [31:0] wide_data = '0;
  logic [7:0]  beat_data;
  logic        beat_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] last_sent = '0;

  always #2.5 clk = ~clk;

  cwf_burst_serializer #(.BEAT_W(8), .QDEPTH(4)) u_cwf_burst_serializer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cwf(req_cwf), .wide_valid(wide_valid), .wide_data(wide_data),
    .beat_data(beat_data), .beat_valid(beat_valid)
  );

  function automatic logic [31:0] make_word(input int base);
    logic [31:0] w;
    for (int s = 0; s < 4; s++) w[8*s +: 8] = 8'((base * 7 + s * 37 + 3) & 255);
    return w;
  endfunction

  function automatic logic [7:0] exp_beat(input logic [31:0] w, input int start, input int k);
    return 8'((w >> (8 * ((start + k) % 4))) & 32'hFF);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic m, input int a);
    req_valid = 1'b1; req_cwf = m; req_addr = 2'(a);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Presents a word, then checks its four beats; returns at the negedge showing beat 3.
  task automatic serve(input logic [31:0] w, input int start, input string req,
                       input bit byp, input logic bm, input int ba);
    wide_valid = 1'b1; wide_data = w;
    if (byp) begin req_valid = 1'b1; req_cwf = bm; req_addr = 2'(ba); end
    @(negedge clk);
    wide_valid = 1'b0; req_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(beat_valid === 1'b1, req, int'(beat_valid), 1);
      check(beat_data === exp_beat(w, start, k), req, int'(beat_data), int'(exp_beat(w, start, k)));
      last_sent = exp_beat(w, start, k);
      if (k < 3) @(negedge clk);
    end
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    check(beat_valid === 1'b0, req, int'(beat_valid), 0);
    check(beat_data === last_sent, req, int'(beat_data), int'(last_sent));
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] wa, wb, wc;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(beat_valid === 1'b0, "R1", int'(beat_valid), 0);
    check(beat_data === 8'h00, "R1", int'(beat_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R8: sweep over mode, address and data
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 4; a++)
        for (int p = 0; p < 3; p++) begin
          push(m[0], a);
          serve(make_word(m * 16 + a * 4 + p), (m == 1) ? a : 0,
                (m == 1) ? "R2/R3/R5" : "R4/R3/R5", 1'b0, 1'b0, 0);
          idle_check("R8/R5");
        end

    // R6: back-to-back bursts chain with no gap
    push(1'b1, 3); push(1'b1, 1); push(1'b0, 2);
    serve(make_word(91), 3, "R6", 1'b0, 1'b0, 0);
    serve(make_word(92), 1, "R6", 1'b0, 1'b0, 0);
    serve(make_word(93), 0, "R6", 1'b0, 1'b0, 0);
    idle_check("R6/R8");

    // R7: word offered on beat 1 is ignored; queued request survives
    push(1'b1, 2); push(1'b1, 1);
    wa = make_word(100); wc = make_word(101); wb = make_word(102);
    wide_valid = 1'b1; wide_data = wa;
    @(negedge clk);
    check(beat_data === exp_beat(wa, 2, 0), "R7", int'(beat_data), int'(exp_beat(wa, 2, 0)));
    wide_data = wc;                         // still valid: offered mid-burst
    @(negedge clk);
    wide_valid = 1'b0;
    for (int k = 1; k < 4; k++) begin
      check(beat_valid === 1'b1, "R7", int'(beat_valid), 1);
      check(beat_data === exp_beat(wa, 2, k), "R7", int'(beat_data), int'(exp_beat(wa, 2, k)));
      last_sent = exp_beat(wa, 2, k);
      if (k < 3) @(negedge clk);
    end
    idle_check("R7");
    serve(wb, 1, "R7", 1'b0, 1'b0, 0);
    idle_check("R7/R8");

    // R9: same-cycle request applies to the word when queue is empty
    serve(make_word(110), 3, "R9", 1'b1, 1'b1, 3);
    idle_check("R9");
    serve(make_word(111), 0, "R9", 1'b1, 1'b0, 2);
    idle_check("R9");

    // R9 R10: overflow drops fifth request; fifth word has none pending
    push(1'b1, 1); push(1'b1, 2); push(1'b1, 3); push(1'b0, 3); push(1'b1, 2);
    serve(make_word(120), 1, "R9", 1'b0, 1'b0, 0);
    serve(make_word(121), 2, "R9", 1'b0, 1'b0, 0);
    serve(make_word(122), 3, "R9", 1'b0, 1'b0, 0);
    serve(make_word(123), 0, "R9", 1'b0, 1'b0, 0);
    serve(make_word(124), 0, "R10", 1'b0, 1'b0, 0);
    idle_check("R10/R8");

    // R10: word with an empty queue starts at slot 0
    serve(make_word(130), 0, "R10", 1'b0, 1'b0, 0);
    idle_check("R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule